// File: doc/BRIEF.md
# Serial Configuration Write Controller

This block is a synchronous serial slave that takes configuration from a host microcontroller before a paging decoder starts working. The host raises an attention line, clocks bits in on a serial clock and data line, and then drops attention to close the frame. A frame of exactly 32 bits is a configuration batch. A frame of exactly 8 bits is a command. Frames of any other length are discarded.

Nine batches are accepted in a fixed order: a parameter word first, then eight address words. Each accepted batch sits in a hold register until the next 1200 Hz processing tick writes it into the table. The block reports BUSY until that happens, and the host can read this status over the serial data-out line. If the serial clock stalls for longer than one tick period while bits are pending, the partial word is dropped. Once all nine batches are stored, a start command ends write mode with a one-cycle start pulse.

Top module: `cfg_serial_loader`

## Requirements
- R1: While `rstN` is low, `paramWord`, every `addrTable` entry, `sdo`, `startPulse` and `errFlag` are 0 and `writeMode` is 1.
- R2: Data bits are taken MSB first on each rising `sck` while `attn` is high. A frame closed by `attn` falling with exactly 32 bits fills the next batch slot in order. Slot 0 is `paramWord` and slots 1 to 8 are `addrTable` entries 0 to 7, found at bits [32k+31:32k]. Batches beyond the ninth change nothing.
- R3: A frame that closes with a bit count other than 8 or 32 is discarded and leaves the block READY.
- R4: An accepted batch makes the block BUSY. It is written to its slot on the first `tick` pulse after acceptance, and BUSY then clears. A 32-bit frame that arrives while BUSY is ignored.
- R5: The 8-bit command 0xA5 is a status read. From the end of that frame until the end of the next frame, `sdo` is 1 for READY and 0 for BUSY. At all other times `sdo` is 0.
- R6: While bits are pending and `attn` is high, GAP_CYCLES clock cycles without a rising `sck` reset the bit count and drop the partial word.
- R7: An address word has an enable flag in bit 31 and an address in bits 20:0. An enabled address word whose address matches an enabled entry in another slot is rejected when its tick arrives. The rejection sets the sticky `errFlag`, leaves the table unchanged and keeps the slot position. A word with the flag clear never counts as a duplicate.
- R8: The 8-bit command 0x5A is accepted only when all nine batches are stored and the block is not BUSY. It then gives one `startPulse` cycle and clears `writeMode`. At any other time it is ignored.
- R9: Once `writeMode` is 0, batches are ignored and the stored configuration stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| attn | input | 1 | Attention; frames a transfer while high |
| sck | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| tick | input | 1 | One-cycle 1200 Hz processing strobe |
| sdo | output | 1 | Status out after a status read (1 READY, 0 BUSY) |
| paramWord | output | 32 | Stored parameter batch |
| addrTable | output | 256 | Eight stored address batches, entry k at [32k+31:32k] |
| startPulse | output | 1 | One-cycle pulse when a start command is accepted |
| writeMode | output | 1 | High while configuration is being written |
| errFlag | output | 1 | Sticky duplicate-address rejection flag |

## Verification
The 32-bit batch path is exercised with four kinds of input: clean frames, a frame sent while a batch is still held (which shows that BUSY discards input rather than queuing it), a frame preceded by a stalled 10-bit fragment (which separates a timeout reset from an ordinary 42-bit discard), and frames past the ninth. A 12-bit frame and start commands sent too early show that framing and ordering are enforced. For duplicates, an enabled copy of a stored address is checked against a disabled copy of the same address, so that the enable flag is shown to take part in the comparison. Status reads are taken both while a batch is held and after it has been written, so that the BUSY and READY encodings are each seen on `sdo`.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int WORD_W = 32;
  localparam int EN_BIT = 31;
  localparam int ADDR_W = 21;
  localparam logic [7:0] CMD_STATUS = 8'hA5;
  localparam logic [7:0] CMD_START  = 8'h5A;

  typedef struct packed {
    logic latchHold;  // capture the shifted word into the hold register
    logic writeSlot;  // move the hold register into the current slot
  } strobes_t;
endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int NUM_ADDR   = 8,
  parameter int GAP_CYCLES = 64,
  parameter int SLOT_W     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       attn,
  input  logic                       sck,
  input  logic                       sdi,
  input  strobes_t                   strobes,
  input  logic [SLOT_W-1:0]          slot,
  output logic                       frameEnd,
  output logic                       len8,
  output logic                       len32,
  output logic [7:0]                 cmdByte,
  output logic                       dupHit,
  output logic [WORD_W-1:0]          paramWord,
  output logic [NUM_ADDR*WORD_W-1:0] addrFlat
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

  logic              sckQ, attnQ, sckRise;
  logic [WORD_W-1:0] shiftReg, holdWord, paramReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [WORD_W-1:0] addrTbl [NUM_ADDR];
  logic [NUM_ADDR-1:0] hitVec;

  assign sckRise  = attn & sck & ~sckQ;
  assign frameEnd = attnQ & ~attn;
  assign len8     = (bitCnt == CNT_W'(8));
  assign len32    = (bitCnt == CNT_W'(WORD_W));
  assign cmdByte  = shiftReg[7:0];

  // Shifter, bit counter and stall timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ     <= 1'b0;
      attnQ    <= 1'b0;
      shiftReg <= '0;
      bitCnt   <= '0;
      gapCnt   <= '0;
    end else begin
      sckQ  <= sck;
      attnQ <= attn;
      if (frameEnd) begin
        bitCnt <= '0;
        gapCnt <= '0;
      end else if (sckRise) begin
        shiftReg <= {shiftReg[WORD_W-2:0], sdi};
        if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
        gapCnt <= '0;
      end else if (attn && bitCnt != '0) begin
        if (gapCnt == GAP_LAST) begin
          bitCnt   <= '0;
          gapCnt   <= '0;
          shiftReg <= '0;
        end else begin
          gapCnt <= gapCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      paramReg <= '0;
    end else begin
      if (strobes.latchHold) holdWord <= shiftReg;
      if (strobes.writeSlot && slot == '0) paramReg <= holdWord;
    end
  end

  assign paramWord = paramReg;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) addrTbl[g] <= '0;
      else if (strobes.writeSlot && slot == SLOT_W'(g + 1)) addrTbl[g] <= holdWord;
    end
    assign addrFlat[g*WORD_W +: WORD_W] = addrTbl[g];
    assign hitVec[g] = holdWord[EN_BIT] & addrTbl[g][EN_BIT]
                     & (addrTbl[g][ADDR_W-1:0] == holdWord[ADDR_W-1:0])
                     & (slot != SLOT_W'(g + 1));
  end

  assign dupHit = |hitVec;

  a_r6_gap_range: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= GAP_LAST);
  a_r3_count_sat: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_SAT);
  a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> bitCnt == '0);
endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int NUM_ADDR = 8,
  parameter int SLOT_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              frameEnd,
  input  logic              len8,
  input  logic              len32,
  input  logic [7:0]        cmdByte,
  input  logic              dupHit,
  output strobes_t          strobes,
  output logic [SLOT_W-1:0] slot,
  output logic              sdo,
  output logic              writeMode,
  output logic              startPulse,
  output logic              errFlag
);
  localparam logic [SLOT_W-1:0] ALL_DONE = SLOT_W'(NUM_ADDR + 1);

  logic busy, statusValid;
  logic batchIn, startCmd, statusCmd, process, reject;
  logic [SLOT_W-1:0] slotCnt;

  always_comb begin
    batchIn   = frameEnd & len32 & writeMode & ~busy & (slotCnt != ALL_DONE);
    startCmd  = frameEnd & len8 & (cmdByte == CMD_START) & writeMode & ~busy
              & (slotCnt == ALL_DONE);
    statusCmd = frameEnd & len8 & (cmdByte == CMD_STATUS);
    process   = tick & busy;
    reject    = process & (slotCnt != '0) & dupHit;
    strobes.latchHold = batchIn;
    strobes.writeSlot = process & ~reject;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      slotCnt     <= '0;
      errFlag     <= 1'b0;
      startPulse  <= 1'b0;
      writeMode   <= 1'b1;
      statusValid <= 1'b0;
    end else begin
      if (batchIn)      busy <= 1'b1;
      else if (process) busy <= 1'b0;
      if (strobes.writeSlot) slotCnt <= slotCnt + 1'b1;
      if (reject) errFlag <= 1'b1;
      startPulse <= startCmd;
      if (startCmd) writeMode <= 1'b0;
      if (frameEnd) statusValid <= statusCmd;
    end
  end

  assign slot = slotCnt;
  assign sdo  = statusValid & ~busy;

  a_r8_start_leaves: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !writeMode);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> busy);
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !writeMode |=> ($stable(slotCnt) && !busy));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= ALL_DONE);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int NUM_ADDR   = 8,
  parameter int GAP_CYCLES = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       attn,
  input  logic                       sck,
  input  logic                       sdi,
  input  logic                       tick,
  output logic                       sdo,
  output logic [WORD_W-1:0]          paramWord,
  output logic [NUM_ADDR*WORD_W-1:0] addrTable,
  output logic                       startPulse,
  output logic                       writeMode,
  output logic                       errFlag
);
  localparam int SLOT_W = $clog2(NUM_ADDR + 2);

  strobes_t          strobes;
  logic [SLOT_W-1:0] slot;
  logic              frameEnd, len8, len32, dupHit;
  logic [7:0]        cmdByte;

  cfg_loader_dp #(.NUM_ADDR(NUM_ADDR), .GAP_CYCLES(GAP_CYCLES), .SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .attn(attn), .sck(sck), .sdi(sdi),
    .strobes(strobes), .slot(slot),
    .frameEnd(frameEnd), .len8(len8), .len32(len32), .cmdByte(cmdByte),
    .dupHit(dupHit), .paramWord(paramWord), .addrFlat(addrTable)
  );

  cfg_loader_ctrl #(.NUM_ADDR(NUM_ADDR), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .frameEnd(frameEnd), .len8(len8), .len32(len32), .cmdByte(cmdByte),
    .dupHit(dupHit), .strobes(strobes), .slot(slot), .sdo(sdo),
    .writeMode(writeMode), .startPulse(startPulse), .errFlag(errFlag)
  );
endmodule

// File: tb/tb_cfg_serial_loader.sv
`timescale 1ns/1ps
module tb_cfg_serial_loader;
  localparam int GAP = 64;
  localparam int TICK_PER = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic attn = 1'b0, sck = 1'b0, sdi = 1'b0, tick = 1'b0;
  logic sdo, startPulse, writeMode, errFlag;
  logic [31:0]  paramWord;
  logic [255:0] addrTable;

  always #2.5 clk = ~clk;

  cfg_serial_loader dut (
    .clk(clk), .rstN(rstN), .attn(attn), .sck(sck), .sdi(sdi), .tick(tick),
    .sdo(sdo), .paramWord(paramWord), .addrTable(addrTable),
    .startPulse(startPulse), .writeMode(writeMode), .errFlag(errFlag)
  );

  int vectors = 0, fails = 0, pulseCnt = 0, tickCnt = 0;
  bit done = 0, armed = 0, tickEn = 1;

  // Tick source
  always @(negedge clk) begin
    tickCnt <= (tickCnt == TICK_PER - 1) ? 0 : tickCnt + 1;
    tick    <= tickEn && (tickCnt == TICK_PER - 1);
  end

  // Behavioural reference model
  bit q[$];
  bit pSck, pAttn, mWrite, mBusy, mErr, mStart, mStat, rise, fall, dup, oldBusy;
  int gap, mSlot, oldSlot, len;
  logic [31:0] mParam, mHold, w;
  logic [31:0] mAddr [8];

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); pSck = 0; pAttn = 0; gap = 0; mSlot = 0;
      mWrite = 1; mBusy = 0; mErr = 0; mStart = 0; mStat = 0;
      mParam = 0; mHold = 0;
      foreach (mAddr[i]) mAddr[i] = 0;
      armed = 1;
    end else begin
      rise = attn && sck && !pSck;
      fall = pAttn && !attn;
      len = q.size();
      w = 0;
      foreach (q[i]) w = {w[30:0], q[i]};
      oldBusy = mBusy; oldSlot = mSlot;
      mStart = 0;
      if (tick && oldBusy) begin
        dup = 0;
        if (oldSlot > 0 && mHold[31])
          for (int j = 1; j <= 8; j++)
            if (j != oldSlot && mAddr[j-1][31] && mAddr[j-1][20:0] == mHold[20:0]) dup = 1;
        if (dup) mErr = 1;
        else begin
          if (oldSlot == 0) mParam = mHold; else mAddr[oldSlot-1] = mHold;
          mSlot = mSlot + 1;
        end
        mBusy = 0;
      end
      if (fall) begin
        if (len == 32 && mWrite && !oldBusy && oldSlot < 9) begin mHold = w; mBusy = 1; end
        if (len == 8 && w[7:0] == 8'h5A && mWrite && !oldBusy && oldSlot == 9) begin
          mStart = 1; mWrite = 0;
        end
        mStat = (len == 8 && w[7:0] == 8'hA5);
        q.delete(); gap = 0;
      end else if (rise) begin
        if (q.size() < 33) q.push_back(sdi);
        gap = 0;
      end else if (attn && q.size() > 0) begin
        gap++;
        if (gap == GAP) begin q.delete(); gap = 0; end
      end
      pSck = sck; pAttn = attn;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      if (startPulse) pulseCnt++;
      check("R5 sdo", {31'd0, sdo}, {31'd0, mStat && !mBusy});
      check("R2 paramWord", paramWord, mParam);
      for (int k = 0; k < 8; k++) check("R2 addrTable", addrTable[k*32 +: 32], mAddr[k]);
      check("R8 startPulse", {31'd0, startPulse}, {31'd0, mStart});
      check("R9 writeMode", {31'd0, writeMode}, {31'd0, mWrite});
      check("R7 errFlag", {31'd0, errFlag}, {31'd0, mErr});
    end
  end

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftOut(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      idle(4); sck = 1'b1;
      idle(4); sck = 1'b0;
    end
  endtask

  task automatic frame(logic [31:0] v, int n);
    @(negedge clk) attn = 1'b1;
    idle(2);
    shiftOut(v, n);
    idle(4); attn = 1'b0;
    idle(4);
  endtask

  task automatic statusRead(string tag, logic expReady);
    frame(32'hA5, 8);
    idle(2);
    check(tag, {31'd0, sdo}, {31'd0, expReady});
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    idle(5);
    check("R1 paramWord", paramWord, 32'd0);
    check("R1 addrTable", {31'd0, |addrTable}, 32'd0);
    check("R1 writeMode", {31'd0, writeMode}, 32'd1);
    check("R1 sdo", {31'd0, sdo}, 32'd0);
    check("R1 errFlag", {31'd0, errFlag}, 32'd0);
    rstN = 1'b1;
    idle(3);
  endtask

  initial begin
    idle(3);
    doReset();
    // R8: early start ignored
    frame(32'h5A, 8);
    check("R8 early start writeMode", {31'd0, writeMode}, 32'd1);
    check("R8 early start pulse", pulseCnt, 0);
    // R3: odd length frame discarded
    frame(32'h0ABC, 12);
    statusRead("R3 odd frame leaves READY", 1'b1);
    // R4/R5: busy while held, second frame ignored
    tickEn = 0;
    frame(32'h1234_5678, 32);
    statusRead("R5 BUSY while held", 1'b0);
    frame(32'hDEAD_BEEF, 32);
    tickEn = 1;
    idle(250);
    check("R4 first held batch stored", paramWord, 32'h1234_5678);
    statusRead("R5 READY after tick", 1'b1);
    // R6: stalled fragment dropped
    @(negedge clk) attn = 1'b1;
    idle(2);
    shiftOut(32'h3FF, 10);
    idle(100);
    shiftOut(32'h8000_1001, 32);
    idle(4); attn = 1'b0;
    idle(254);
    check("R6 word after stall stored", addrTable[31:0], 32'h8000_1001);
    // R7: duplicate enabled address rejected
    frame(32'h8000_1001, 32);
    idle(250);
    check("R7 duplicate sets errFlag", {31'd0, errFlag}, 32'd1);
    check("R7 duplicate not stored", addrTable[63:32], 32'd0);
    for (int k = 1; k <= 7; k++) begin
      frame((k == 7) ? 32'h0000_1001 : (32'h8000_0000 | (k * 32'h1111)), 32);
      idle(250);
    end
    check("R7 disabled copy stored", addrTable[255:224], 32'h0000_1001);
    check("R2 slot order", addrTable[63:32], 32'h8000_1111);
    // R2: tenth batch ignored
    frame(32'hFFFF_FFFF, 32);
    idle(250);
    check("R2 extra batch param", paramWord, 32'h1234_5678);
    check("R2 extra batch last entry", addrTable[255:224], 32'h0000_1001);
    statusRead("R5 READY when full", 1'b1);
    // R8: start accepted
    frame(32'h5A, 8);
    check("R8 start pulse count", pulseCnt, 1);
    check("R8 writeMode cleared", {31'd0, writeMode}, 32'd0);
    // R9: batches ignored after start
    frame(32'h1111_1111, 32);
    idle(250);
    check("R9 param kept", paramWord, 32'h1234_5678);
    statusRead("R9 not busy after start", 1'b1);
    // R1: reset returns to write mode
    doReset();
    check("R1 after second reset", {31'd0, writeMode}, 32'd1);
    idle(5);
    finishRun();
  end
endmodule